// File: doc/BRIEF.md
# Debug Status and Control Register

This block is the 32-bit status and control word that an external debugger reads and writes to watch and steer a processor core. Four control fields can be written: a two-bit interrupt mask, a trap of debug-register access, a memory-access mode and a halting-debug enable. The other fields report core status. How they read back depends on whether the core is in Debug state. Some status fields show live core signals only while the core is halted. Others are captured or cleared when the core enters Debug state. A group of sticky flags records instruction retirement, overruns, underruns and errors.

The debugger side is a single-cycle write strobe with a 32-bit data word and a combinational read word. The core side gives entry and exit pulses for Debug state, the current exception level, the per-level register-width vector, the security state, the secure-debug-enable level, a retire pulse and overrun/underrun pulses. The clear strobes for the pipeline-advance flag and for the sticky error flags come in as separate pulses. The parameter `HIGH_EL` tells the block whether the core has its two highest exception levels.

Top module: `dbgsc_reg`

## Requirements
- R1: After synchronous reset, every stored field is zero and the core is in the running (Non-debug) state. With secure debug enabled, `rd_data` therefore reads 0x00003C00.
- R2: Bits 9:8 of `rd_data` show `cur_el` while in Debug state and read zero outside it.
- R3: Bits 13:10 of `rd_data` show `reg_width` while in Debug state and read as 4'b1111 outside it.
- R4: Bit 18 of `rd_data` shows `is_nonsecure` while in Debug state and reads zero outside it.
- R5: On Debug entry, bit 16 captures 0 if `is_nonsecure` is 0, and otherwise captures the inverse of `sec_dbg_en`. It holds that value for the rest of Debug state. Outside Debug state it reads the inverse of `sec_dbg_en` live.
- R6: A write stores only bits 23:22 (interrupt mask), 21 (trap), 20 (memory-access mode) and 14 (halting enable). Every other written bit is ignored, and unused bits read zero.
- R7: With `HIGH_EL`=0, bit 22 cannot be written and always equals bit 23, so a write of data bit 22 alone leaves the mask at 00.
- R8: The memory-access mode bit is cleared on Debug entry, and this takes priority over a write in the same cycle. `mem_acc_o` is that bit ANDed with Debug state, so the bit has no effect while the core is running.
- R9: Bit 25 sets on a `retire` pulse and clears only on `clr_pipe_adv`. When both arrive in the same cycle, the set wins.
- R10: Bit 6 (error) sets on any overrun or underrun pulse, and on `exc_in_dbg` only while in Debug state. `clr_err` clears it, and a set in the same cycle wins.
- R11: Bit 28 sets on `itr_ovr` and is cleared on Debug entry, with entry taking priority. Bits 27 and 26 set on `rx_ovr` and `tx_udr` respectively. `clr_err` clears all three.
- R12: `in_debug` rises one cycle after a `dbg_enter` pulse and falls one cycle after `dbg_exit`. When both pulses arrive together, entry wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe from the debugger |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational readback word |
| dbg_enter | input | 1 | Core enters Debug state (pulse) |
| dbg_exit | input | 1 | Core leaves Debug state (pulse) |
| cur_el | input | 2 | Current exception level |
| reg_width | input | 4 | Per-level register-width status |
| is_nonsecure | input | 1 | Core security state, 1 = Non-secure |
| sec_dbg_en | input | 1 | Secure invasive debug enabled |
| retire | input | 1 | One or more instructions retired |
| clr_pipe_adv | input | 1 | Clear the pipeline-advance flag |
| clr_err | input | 1 | Clear the sticky error flags |
| exc_in_dbg | input | 1 | Exception taken (pulse) |
| rx_ovr | input | 1 | Receive transfer overrun pulse |
| tx_udr | input | 1 | Transmit transfer underrun pulse |
| itr_ovr | input | 1 | Instruction transfer overrun pulse |
| in_debug | output | 1 | Core is in Debug state |
| intdis_o | output | 2 | Interrupt mask control |
| trap_o | output | 1 | Debug-register access trap control |
| mem_acc_o | output | 1 | Effective memory-access mode |
| halt_en_o | output | 1 | Halting-debug enable |

## Verification
Stored fields, the sticky flags and `in_debug` take one register stage. Their effect shows on `rd_data` in the cycle after the strobe or pulse. The live fields (level, width, security state and, outside Debug state, the secure-debug bit) are combinational from the inputs and change within the same cycle. The bench drives inputs just after a falling edge and checks registered results at the next falling edge, after exactly one rising edge has passed. It checks live fields a short delay after changing the input, with no clock edge in between. Same-cycle collisions are driven in one falling-edge window so that the priority rule alone decides the result.

// File: rtl/dbgsc_pkg.sv
package dbgsc_pkg;
    localparam int REG_W = 32;
    localparam int EL_W  = 2;
    localparam int RWV_W = 4;

    localparam int P_ITO   = 28;
    localparam int P_RXO   = 27;
    localparam int P_TXU   = 26;
    localparam int P_PADV  = 25;
    localparam int P_IMSK  = 22;
    localparam int P_TRAP  = 21;
    localparam int P_MACC  = 20;
    localparam int P_NSEC  = 18;
    localparam int P_SDIS  = 16;
    localparam int P_HALT  = 14;
    localparam int P_RWID  = 10;
    localparam int P_ELVL  = 8;
    localparam int P_ERR   = 6;

    typedef enum logic {ST_RUN = 1'b0, ST_HALTED = 1'b1} dstate_e;

    typedef struct packed {
        logic [1:0] imsk;
        logic       trap;
        logic       macc;
        logic       halt;
    } ctrl_t;

    typedef struct packed {
        logic ito;
        logic rxo;
        logic txu;
        logic padv;
        logic err;
    } flags_t;

    function automatic ctrl_t ctrl_from_word(logic [REG_W-1:0] w, logic high_el);
        ctrl_t c;
        c.imsk = high_el ? w[P_IMSK+1:P_IMSK] : {w[P_IMSK+1], w[P_IMSK+1]};
        c.trap = w[P_TRAP];
        c.macc = w[P_MACC];
        c.halt = w[P_HALT];
        return c;
    endfunction
endpackage

// File: rtl/dbgsc_state.sv
module dbgsc_state
    import dbgsc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic dbg_enter,
    input  logic dbg_exit,
    input  logic is_nonsecure,
    input  logic sec_dbg_en,
    output logic halted,
    output logic sdis_cap
);
    dstate_e st_q;

    always_ff @(posedge clk) begin
        if (rst)            st_q <= ST_RUN;
        else if (dbg_enter) st_q <= ST_HALTED;
        else if (dbg_exit)  st_q <= ST_RUN;
    end

    always_ff @(posedge clk) begin
        if (rst)            sdis_cap <= 1'b0;
        else if (dbg_enter) sdis_cap <= is_nonsecure ? ~sec_dbg_en : 1'b0;
    end

    assign halted = (st_q == ST_HALTED);

    AST_ENTER_HALTS: assert property (@(posedge clk) disable iff (rst)
        dbg_enter |=> halted); // R12
    AST_EXIT_RUNS: assert property (@(posedge clk) disable iff (rst)
        (dbg_exit && !dbg_enter) |=> !halted); // R12
endmodule

// File: rtl/dbgsc_ctrl.sv
module dbgsc_ctrl
    import dbgsc_pkg::*;
#(
    parameter bit HIGH_EL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             dbg_enter,
    output ctrl_t            ctrl
);
    ctrl_t nxt;

    always_comb begin
        nxt = ctrl;
        if (wr_en) nxt = ctrl_from_word(wr_data, HIGH_EL);
        if (dbg_enter) nxt.macc = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl <= '0;
        else     ctrl <= nxt;
    end

    AST_MACC_ENTRY_CLR: assert property (@(posedge clk) disable iff (rst)
        dbg_enter |=> !ctrl.macc); // R8

    generate
        if (!HIGH_EL) begin : g_mirror
            AST_IMSK_MIRROR: assert property (@(posedge clk) disable iff (rst)
                wr_en |=> (ctrl.imsk == {2{$past(wr_data[P_IMSK+1])}})); // R7
        end
    endgenerate
endmodule

// File: rtl/dbgsc_flags.sv
module dbgsc_flags
    import dbgsc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   halted,
    input  logic   dbg_enter,
    input  logic   retire,
    input  logic   clr_pipe_adv,
    input  logic   clr_err,
    input  logic   exc_in_dbg,
    input  logic   rx_ovr,
    input  logic   tx_udr,
    input  logic   itr_ovr,
    output flags_t flg
);
    logic err_set;
    assign err_set = rx_ovr | tx_udr | itr_ovr | (exc_in_dbg & halted);

    always_ff @(posedge clk) begin
        if (rst) begin
            flg <= '0;
        end else begin
            if (retire)            flg.padv <= 1'b1;
            else if (clr_pipe_adv) flg.padv <= 1'b0;

            if (err_set)      flg.err <= 1'b1;
            else if (clr_err) flg.err <= 1'b0;

            if (rx_ovr)       flg.rxo <= 1'b1;
            else if (clr_err) flg.rxo <= 1'b0;

            if (tx_udr)       flg.txu <= 1'b1;
            else if (clr_err) flg.txu <= 1'b0;

            if (dbg_enter)    flg.ito <= 1'b0;
            else if (itr_ovr) flg.ito <= 1'b1;
            else if (clr_err) flg.ito <= 1'b0;
        end
    end

    AST_PADV_SET: assert property (@(posedge clk) disable iff (rst)
        retire |=> flg.padv); // R9
    AST_ERR_OVR_SET: assert property (@(posedge clk) disable iff (rst)
        (rx_ovr || tx_udr || itr_ovr) |=> flg.err); // R10
    AST_ERR_RUN_EXC: assert property (@(posedge clk) disable iff (rst)
        (!halted && exc_in_dbg && !rx_ovr && !tx_udr && !itr_ovr && !flg.err) |=> !flg.err); // R10
    AST_ITO_ENTRY_CLR: assert property (@(posedge clk) disable iff (rst)
        dbg_enter |=> !flg.ito); // R11
endmodule

// File: rtl/dbgsc_reg.sv
module dbgsc_reg
    import dbgsc_pkg::*;
#(
    parameter bit HIGH_EL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             dbg_enter,
    input  logic             dbg_exit,
    input  logic [EL_W-1:0]  cur_el,
    input  logic [RWV_W-1:0] reg_width,
    input  logic             is_nonsecure,
    input  logic             sec_dbg_en,
    input  logic             retire,
    input  logic             clr_pipe_adv,
    input  logic             clr_err,
    input  logic             exc_in_dbg,
    input  logic             rx_ovr,
    input  logic             tx_udr,
    input  logic             itr_ovr,
    output logic             in_debug,
    output logic [1:0]       intdis_o,
    output logic             trap_o,
    output logic             mem_acc_o,
    output logic             halt_en_o
);
    logic   halted;
    logic   sdis_cap;
    ctrl_t  ctrl;
    flags_t flg;

    dbgsc_state u_state (
        .clk(clk), .rst(rst), .dbg_enter(dbg_enter), .dbg_exit(dbg_exit),
        .is_nonsecure(is_nonsecure), .sec_dbg_en(sec_dbg_en),
        .halted(halted), .sdis_cap(sdis_cap)
    );

    dbgsc_ctrl #(.HIGH_EL(HIGH_EL)) u_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .dbg_enter(dbg_enter), .ctrl(ctrl)
    );

    dbgsc_flags u_flags (
        .clk(clk), .rst(rst), .halted(halted), .dbg_enter(dbg_enter),
        .retire(retire), .clr_pipe_adv(clr_pipe_adv), .clr_err(clr_err),
        .exc_in_dbg(exc_in_dbg), .rx_ovr(rx_ovr), .tx_udr(tx_udr),
        .itr_ovr(itr_ovr), .flg(flg)
    );

    always_comb begin
        rd_data                       = '0;
        rd_data[P_ITO]                = flg.ito;
        rd_data[P_RXO]                = flg.rxo;
        rd_data[P_TXU]                = flg.txu;
        rd_data[P_PADV]               = flg.padv;
        rd_data[P_IMSK+1:P_IMSK]      = ctrl.imsk;
        rd_data[P_TRAP]               = ctrl.trap;
        rd_data[P_MACC]               = ctrl.macc;
        rd_data[P_NSEC]               = halted & is_nonsecure;
        rd_data[P_SDIS]               = halted ? sdis_cap : ~sec_dbg_en;
        rd_data[P_HALT]               = ctrl.halt;
        rd_data[P_RWID+RWV_W-1:P_RWID] = halted ? reg_width : {RWV_W{1'b1}};
        rd_data[P_ELVL+EL_W-1:P_ELVL] = halted ? cur_el : '0;
        rd_data[P_ERR]                = flg.err;
    end

    assign in_debug  = halted;
    assign intdis_o  = ctrl.imsk;
    assign trap_o    = ctrl.trap;
    assign mem_acc_o = ctrl.macc & halted;
    assign halt_en_o = ctrl.halt;

    AST_SDIS_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (halted && !dbg_enter && !dbg_exit) |=> $stable(rd_data[P_SDIS])); // R5
    AST_MACC_INERT: assert property (@(posedge clk) disable iff (rst)
        !in_debug |-> !mem_acc_o); // R8
endmodule

// File: tb/dbgsc_reg_tb.sv
`timescale 1ns/1ps
module dbgsc_reg_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 0;
    logic [31:0] wr_data = '0;
    logic dbg_enter = 0, dbg_exit = 0;
    logic [1:0] cur_el = '0;
    logic [3:0] reg_width = '0;
    logic is_nonsecure = 0, sec_dbg_en = 1;
    logic retire = 0, clr_pipe_adv = 0, clr_err = 0, exc_in_dbg = 0;
    logic rx_ovr = 0, tx_udr = 0, itr_ovr = 0;
    logic [31:0] rd_data, rd_lo;
    logic in_debug, trap_o, mem_acc_o, halt_en_o;
    logic [1:0] intdis_o, intdis_lo;
    logic in_lo, trap_lo, macc_lo, halt_lo;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dbgsc_reg u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .dbg_enter(dbg_enter), .dbg_exit(dbg_exit), .cur_el(cur_el), .reg_width(reg_width),
        .is_nonsecure(is_nonsecure), .sec_dbg_en(sec_dbg_en), .retire(retire),
        .clr_pipe_adv(clr_pipe_adv), .clr_err(clr_err), .exc_in_dbg(exc_in_dbg),
        .rx_ovr(rx_ovr), .tx_udr(tx_udr), .itr_ovr(itr_ovr), .in_debug(in_debug),
        .intdis_o(intdis_o), .trap_o(trap_o), .mem_acc_o(mem_acc_o), .halt_en_o(halt_en_o)
    );

    dbgsc_reg #(.HIGH_EL(1'b0)) u_dut_lo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_lo),
        .dbg_enter(dbg_enter), .dbg_exit(dbg_exit), .cur_el(cur_el), .reg_width(reg_width),
        .is_nonsecure(is_nonsecure), .sec_dbg_en(sec_dbg_en), .retire(retire),
        .clr_pipe_adv(clr_pipe_adv), .clr_err(clr_err), .exc_in_dbg(exc_in_dbg),
        .rx_ovr(rx_ovr), .tx_udr(tx_udr), .itr_ovr(itr_ovr), .in_debug(in_lo),
        .intdis_o(intdis_lo), .trap_o(trap_lo), .mem_acc_o(macc_lo), .halt_en_o(halt_lo)
    );

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // one cycle: inputs set by caller after a falling edge, this waits one rising edge and drops pulses
    task automatic tick();
        @(negedge clk);
        wr_en = 0; dbg_enter = 0; dbg_exit = 0; retire = 0; clr_pipe_adv = 0;
        clr_err = 0; exc_in_dbg = 0; rx_ovr = 0; tx_udr = 0; itr_ovr = 0;
    endtask

    task automatic wr(logic [31:0] d);
        wr_en = 1; wr_data = d; tick();
    endtask

    task automatic t_reset();
        chk("R1 reset readback", rd_data, 32'h0000_3C00);
        chk("R1 reset state", {31'd0, in_debug}, 32'd0);
    endtask

    task automatic t_write();
        wr(32'hFFFF_FFFF);
        chk("R6 write all ones", rd_data, 32'h00F0_7C00);
        chk("R8 mode inert while running", {31'd0, mem_acc_o}, 32'd0);
        wr(32'h00A0_0000);
        chk("R6 partial write", rd_data, 32'h00A0_3C00);
        chk("R6 mask port", {30'd0, intdis_o}, 32'd2);
        wr(32'h0000_0000);
        chk("R6 clear", rd_data, 32'h0000_3C00);
    endtask

    task automatic t_mirror();
        wr(32'h0040_0000);
        chk("R7 low bit alone", rd_lo, 32'h0000_3C00);
        chk("R7 full variant keeps 01", rd_data, 32'h0040_3C00);
        wr(32'h0080_0000);
        chk("R7 high bit mirrors", rd_lo, 32'h00C0_3C00);
        wr(32'h0000_0000);
    endtask

    task automatic t_debug();
        wr(32'h0010_0000);
        cur_el = 2'd2; reg_width = 4'b0111; is_nonsecure = 1; sec_dbg_en = 0;
        #1;
        chk("R2 R3 R4 live fields hidden while running", rd_data, 32'h0011_3C00);
        @(negedge clk);
        dbg_enter = 1; wr_en = 1; wr_data = 32'h0010_0000;
        tick();
        chk("R12 entry", {31'd0, in_debug}, 32'd1);
        chk("R2 R3 R4 R5 R8 halted readback", rd_data, 32'h0005_1E00);
        sec_dbg_en = 1; cur_el = 2'd1; #1;
        chk("R5 frozen in debug", {31'd0, rd_data[16]}, 32'd1);
        chk("R2 live level", {30'd0, rd_data[9:8]}, 32'd1);
        wr(32'h0010_0000);
        chk("R8 mode active in debug", {31'd0, mem_acc_o}, 32'd1);
        dbg_exit = 1; tick();
        chk("R12 exit", {31'd0, in_debug}, 32'd0);
        chk("R8 R5 running readback", rd_data, 32'h0010_3C00);
        chk("R8 inert after exit", {31'd0, mem_acc_o}, 32'd0);
        is_nonsecure = 0; sec_dbg_en = 0;
        dbg_enter = 1; dbg_exit = 1; tick();
        chk("R12 entry wins", {31'd0, in_debug}, 32'd1);
        chk("R5 secure entry", {31'd0, rd_data[16]}, 32'd0);
        dbg_exit = 1; tick();
        sec_dbg_en = 1; wr(32'h0);
    endtask

    task automatic t_padv();
        retire = 1; tick();
        chk("R9 set", {31'd0, rd_data[25]}, 32'd1);
        retire = 1; clr_pipe_adv = 1; tick();
        chk("R9 set wins", {31'd0, rd_data[25]}, 32'd1);
        clr_pipe_adv = 1; tick();
        chk("R9 clear", {31'd0, rd_data[25]}, 32'd0);
    endtask

    task automatic t_err();
        exc_in_dbg = 1; tick();
        chk("R10 exception ignored running", {31'd0, rd_data[6]}, 32'd0);
        rx_ovr = 1; tick();
        chk("R10 R11 rx overrun", rd_data & 32'h1C00_0040, 32'h0800_0040);
        clr_err = 1; tick();
        chk("R10 R11 cleared", rd_data & 32'h1C00_0040, 32'h0);
        clr_err = 1; tx_udr = 1; tick();
        chk("R10 R11 set beats clear", rd_data & 32'h1C00_0040, 32'h0400_0040);
        clr_err = 1; tick();
        dbg_enter = 1; tick();
        exc_in_dbg = 1; tick();
        chk("R10 exception in debug", {31'd0, rd_data[6]}, 32'd1);
        clr_err = 1; dbg_exit = 1; tick();
    endtask

    task automatic t_ito();
        itr_ovr = 1; tick();
        chk("R11 instr overrun", rd_data & 32'h1000_0040, 32'h1000_0040);
        dbg_enter = 1; itr_ovr = 1; tick();
        chk("R11 entry clears", rd_data & 32'h1000_0040, 32'h0000_0040);
        dbg_exit = 1; tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_write();
        t_mirror();
        t_debug();
        t_padv();
        t_err();
        t_ito();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule